// File: doc/BRIEF.md
# Baseline-Compensated Hit Discriminator

This block decides, channel by channel, whether a digitized pulse is large enough for amplitude reconstruction to be worth running. After a trigger, the samples of `NUM_CH` channels arrive one channel after another. Each channel is a window of `NUM_SAMPLES` consecutive samples. Two configured positions in that window matter. The peak position selects two adjacent samples, and their average is the peak level. The baseline position selects four adjacent samples that come before the pulse, and their average is the local baseline. Both averages are formed by shifting and truncating, with no divider.

In differential mode the decision uses the peak level minus the local baseline, so a slow drift of the pedestal does not move the effective threshold. In absolute mode the peak level alone is compared with the threshold. Each decision is reported as a one-cycle result carrying the channel number. Once the last channel is decided, a mask with one bit per channel is presented. Downstream logic uses each result to gate reconstruction of that channel and uses the mask as the amplitude-presence pattern.

Top module: `hit_discriminator`

## Requirements
- R1: While reset is held and right after it is released, `res_valid` and `mask_valid` are low and `hit_mask` is all zeros.
- R2: The peak level is floor((s[p] + s[p+1]) / 2) and the baseline level is floor((s[b] + s[b+1] + s[b+2] + s[b+3]) / 4). Here s[i] is the channel's i-th sample counted from 0, p is the peak index and b is the baseline index.
- R3: With `cfg_mode` = 1 (differential), a channel is a hit exactly when peak level minus baseline level is greater than or equal to `cfg_thr`. A difference equal to the threshold counts as a hit.
- R4: In differential mode, a peak level below the baseline level is never a hit, even when `cfg_thr` is 0.
- R5: With `cfg_mode` = 0 (absolute), a channel is a hit exactly when the peak level is greater than or equal to `cfg_thr`, whatever the baseline samples hold.
- R6: `cfg_mode`, `cfg_thr`, `cfg_peak_idx` and `cfg_base_idx` are captured in the cycle `trig_start` is high. Changing them later in the same trigger has no effect on the results.
- R7: The first accepted sample after `trig_start` belongs to channel 0. After each `NUM_SAMPLES` accepted samples the channel number advances. `res_valid` pulses for one cycle with `res_chan` equal to that channel, at the second rising edge after the edge that accepts the channel's last sample.
- R8: Bit n of `hit_mask` equals the decision for channel n. `mask_valid` pulses together with the result of channel `NUM_CH`-1, and `hit_mask` then holds its value until the next `trig_start`.
- R9: Samples offered before the first `trig_start`, or after all `NUM_CH` channels of a trigger have been evaluated, produce no result.
- R10: A `trig_start` during a trigger restarts counting at channel 0, sample 0, and drops the partly received channel. On the edge that sees `trig_start`, `hit_mask` is cleared to zero.
- R11: Only cycles with `smp_valid` high count as samples. Idle cycles between samples, inside a channel or between channels, do not change any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_start | input | 1 | Starts a new trigger and captures the configuration |
| cfg_mode | input | 1 | 1 selects the differential decision, 0 the absolute one |
| cfg_thr | input | THR_W (18) | Unsigned hit threshold |
| cfg_peak_idx | input | IDX_W (5) | Index of the first of the two peak samples |
| cfg_base_idx | input | IDX_W (5) | Index of the first of the four baseline samples |
| smp_valid | input | 1 | Qualifies `smp_data` |
| smp_data | input | DATA_W (18) | Unsigned ADC sample |
| res_valid | output | 1 | One-cycle pulse: one channel has been decided |
| res_hit | output | 1 | Decision for channel `res_chan` |
| res_chan | output | CH_W (4) | Channel number of the current result |
| mask_valid | output | 1 | One-cycle pulse: all channels are decided |
| hit_mask | output | NUM_CH (16) | Bit n set when channel n is a hit |

## Verification
A channel result is due exactly two rising edges after the edge that accepts that channel's last sample. The bench records the due cycle at the moment it drives that sample, and it checks at the falling edge that the result appears in that cycle and in no other. The mask is due in the same cycle as the result of the last channel. After `trig_start`, the cleared mask is checked at the very next falling edge. Ignored stimulus is checked in two ways: any result that appears while no channel is owed counts as a failure, and the held mask is compared again after the extra samples.

// File: rtl/hd_pkg.sv
package hd_pkg;

    typedef enum logic {
        HD_MODE_ABS  = 1'b0,
        HD_MODE_DIFF = 1'b1
    } hd_mode_e;

endpackage

// File: rtl/hd_tracker.sv
module hd_tracker #(
    parameter int NUM_CH      = 16,
    parameter int NUM_SAMPLES = 31,
    parameter int IDX_W       = $clog2(NUM_SAMPLES),
    parameter int CH_W        = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_start,
    input  logic             smp_valid,
    output logic             take,
    output logic [IDX_W-1:0] smp_idx,
    output logic             chan_done,
    output logic [CH_W-1:0]  done_chan
);

    localparam logic [IDX_W-1:0] LAST_SMP = IDX_W'(NUM_SAMPLES - 1);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] smp_idx;
        logic [CH_W-1:0]  chan_idx;
        logic             done;
        logic [CH_W-1:0]  done_chan;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = 1'b0;
        if (trig_start) begin
            trk_d.active   = 1'b1;
            trk_d.smp_idx  = '0;
            trk_d.chan_idx = '0;
        end else if (trk_q.active && smp_valid) begin
            if (trk_q.smp_idx == LAST_SMP) begin
                trk_d.smp_idx   = '0;
                trk_d.done      = 1'b1;
                trk_d.done_chan = trk_q.chan_idx;
                if (trk_q.chan_idx == LAST_CH) begin
                    trk_d.active   = 1'b0;
                    trk_d.chan_idx = '0;
                end else begin
                    trk_d.chan_idx = trk_q.chan_idx + CH_W'(1);
                end
            end else begin
                trk_d.smp_idx = trk_q.smp_idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign take      = trk_q.active && smp_valid && !trig_start;
    assign smp_idx   = trk_q.smp_idx;
    assign chan_done = trk_q.done;
    assign done_chan = trk_q.done_chan;

    // R7: a channel spans several samples, so completions never come back to back
    a_r7_done_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |=> !chan_done);

    // R9: with no trigger running, no channel can complete
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_q.active && !trig_start) |=> !chan_done);

    // R10: a restart discards any completion pending from the interrupted trigger
    a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        trig_start |=> !chan_done);

endmodule

// File: rtl/hd_accum.sv
module hd_accum #(
    parameter int DATA_W = 18,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [IDX_W-1:0]  smp_idx,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [IDX_W-1:0]  pk_idx,
    input  logic [IDX_W-1:0]  bs_idx,
    output logic [DATA_W:0]   peak_sum,
    output logic [DATA_W+1:0] base_sum
);

    localparam int XW = IDX_W + 1;
    localparam logic [DATA_W:0]   PK_MAX = {{DATA_W{1'b1}}, 1'b0};
    localparam logic [DATA_W+1:0] BS_MAX = {{DATA_W{1'b1}}, 2'b00};

    typedef struct packed {
        logic [DATA_W:0]   peak;
        logic [DATA_W+1:0] base;
    } acc_t;

    acc_t acc_d, acc_q;

    logic [XW-1:0] idx_x, pk_x, bs_x;
    logic          in_peak, in_base;

    always_comb begin
        idx_x   = XW'(smp_idx);
        pk_x    = XW'(pk_idx);
        bs_x    = XW'(bs_idx);
        in_peak = (idx_x == pk_x) || (idx_x == pk_x + XW'(1));
        in_base = (idx_x >= bs_x) && (idx_x <= bs_x + XW'(3));
    end

    always_comb begin
        acc_d = acc_q;
        if (take) begin
            acc_d.peak = ((smp_idx == '0) ? '0 : acc_q.peak)
                       + (in_peak ? (DATA_W+1)'(smp_data) : '0);
            acc_d.base = ((smp_idx == '0) ? '0 : acc_q.base)
                       + (in_base ? (DATA_W+2)'(smp_data) : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign peak_sum = acc_q.peak;
    assign base_sum = acc_q.base;

    // R2: at most two samples ever land in the peak sum
    a_r2_peak_bound: assert property (@(posedge clk) disable iff (!rst_n)
        peak_sum <= PK_MAX);

    // R2: at most four samples ever land in the baseline sum
    a_r2_base_bound: assert property (@(posedge clk) disable iff (!rst_n)
        base_sum <= BS_MAX);

endmodule

// File: rtl/hd_decide.sv
module hd_decide
    import hd_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int THR_W  = 18
) (
    input  logic [DATA_W:0]   peak_sum,
    input  logic [DATA_W+1:0] base_sum,
    input  hd_mode_e          mode,
    input  logic [THR_W-1:0]  thr,
    output logic              hit
);

    localparam int CMP_W = ((DATA_W > THR_W) ? DATA_W : THR_W) + 1;

    logic [DATA_W-1:0] peak_lvl, base_lvl;
    logic [DATA_W:0]   diff;
    logic              diff_neg;
    logic              hit_diff, hit_abs;
    logic              unused_lsb;

    always_comb begin
        peak_lvl = peak_sum[DATA_W:1];
        base_lvl = base_sum[DATA_W+1:2];
        diff     = {1'b0, peak_lvl} - {1'b0, base_lvl};
        diff_neg = diff[DATA_W];
        hit_diff = !diff_neg && (CMP_W'(diff[DATA_W-1:0]) >= CMP_W'(thr));
        hit_abs  = CMP_W'(peak_lvl) >= CMP_W'(thr);
        hit      = (mode == HD_MODE_DIFF) ? hit_diff : hit_abs;
    end

    assign unused_lsb = ^{peak_sum[0], base_sum[1:0]};

endmodule

// File: rtl/hit_discriminator.sv
module hit_discriminator
    import hd_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int NUM_SAMPLES = 31,
    parameter int DATA_W      = 18,
    parameter int THR_W       = 18,
    parameter int IDX_W       = $clog2(NUM_SAMPLES),
    parameter int CH_W        = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_start,
    input  logic              cfg_mode,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic [IDX_W-1:0]  cfg_peak_idx,
    input  logic [IDX_W-1:0]  cfg_base_idx,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              res_valid,
    output logic              res_hit,
    output logic [CH_W-1:0]   res_chan,
    output logic              mask_valid,
    output logic [NUM_CH-1:0] hit_mask
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    typedef struct packed {
        hd_mode_e          mode;
        logic [THR_W-1:0]  thr;
        logic [IDX_W-1:0]  pk;
        logic [IDX_W-1:0]  bs;
        logic              res_valid;
        logic              res_hit;
        logic [CH_W-1:0]   res_chan;
        logic              mask_valid;
        logic [NUM_CH-1:0] mask;
    } top_t;

    top_t top_d, top_q;

    logic              take;
    logic [IDX_W-1:0]  smp_idx;
    logic              chan_done;
    logic [CH_W-1:0]   done_chan;
    logic [DATA_W:0]   peak_sum;
    logic [DATA_W+1:0] base_sum;
    logic              hit;
    logic [NUM_CH-1:0] mask_upd;

    hd_tracker #(
        .NUM_CH      (NUM_CH),
        .NUM_SAMPLES (NUM_SAMPLES),
        .IDX_W       (IDX_W),
        .CH_W        (CH_W)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_start (trig_start),
        .smp_valid  (smp_valid),
        .take       (take),
        .smp_idx    (smp_idx),
        .chan_done  (chan_done),
        .done_chan  (done_chan)
    );

    hd_accum #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .smp_idx  (smp_idx),
        .smp_data (smp_data),
        .pk_idx   (top_q.pk),
        .bs_idx   (top_q.bs),
        .peak_sum (peak_sum),
        .base_sum (base_sum)
    );

    hd_decide #(
        .DATA_W (DATA_W),
        .THR_W  (THR_W)
    ) u_decide (
        .peak_sum (peak_sum),
        .base_sum (base_sum),
        .mode     (top_q.mode),
        .thr      (top_q.thr),
        .hit      (hit)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_mask
        assign mask_upd[n] = top_q.mask[n] | (hit && (done_chan == CH_W'(n)));
    end

    always_comb begin
        top_d            = top_q;
        top_d.res_valid  = 1'b0;
        top_d.mask_valid = 1'b0;
        if (trig_start) begin
            top_d.mode = hd_mode_e'(cfg_mode);
            top_d.thr  = cfg_thr;
            top_d.pk   = cfg_peak_idx;
            top_d.bs   = cfg_base_idx;
            top_d.mask = '0;
        end else if (chan_done) begin
            top_d.res_valid  = 1'b1;
            top_d.res_hit    = hit;
            top_d.res_chan   = done_chan;
            top_d.mask       = mask_upd;
            top_d.mask_valid = (done_chan == LAST_CH);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign res_valid  = top_q.res_valid;
    assign res_hit    = top_q.res_hit;
    assign res_chan   = top_q.res_chan;
    assign mask_valid = top_q.mask_valid;
    assign hit_mask   = top_q.mask;

    // R8: the mask is complete exactly when the last channel reports
    a_r8_mask_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid |-> (res_valid && res_chan == LAST_CH));

    // R8: the last channel's mask bit agrees with its reported decision
    a_r8_mask_bit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid |-> (hit_mask[NUM_CH-1] == res_hit));

    // R10: a trigger start clears the mask and suppresses any result
    a_r10_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        trig_start |=> (hit_mask == '0 && !res_valid));

    // R7: a result pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

// File: tb/test_hit_discriminator.sv
module test_hit_discriminator;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 16;
    localparam int NS         = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_start = 1'b0;
    logic        cfg_mode = 1'b0;
    logic [17:0] cfg_thr = '0;
    logic [4:0]  cfg_peak_idx = '0;
    logic [4:0]  cfg_base_idx = '0;
    logic        smp_valid = 1'b0;
    logic [17:0] smp_data = '0;
    logic        res_valid, res_hit, mask_valid;
    logic [3:0]  res_chan;
    logic [15:0] hit_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    hit_discriminator i_hit_discriminator (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_start   (trig_start),
        .cfg_mode     (cfg_mode),
        .cfg_thr      (cfg_thr),
        .cfg_peak_idx (cfg_peak_idx),
        .cfg_base_idx (cfg_base_idx),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .res_valid    (res_valid),
        .res_hit      (res_hit),
        .res_chan     (res_chan),
        .mask_valid   (mask_valid),
        .hit_mask     (hit_mask)
    );

    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    int          smp_mem [NCH][NS];
    int          due [NCH];
    bit          exp_hit [NCH];
    logic [15:0] exp_mask = '0;
    int          n_exp = 0;
    int          ptr = 0;
    bit          t_mode;
    int          t_thr, t_pk, t_bs;
    string       t_tag = "R3";

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit model_hit(int ch);
        int p, b;
        p = (smp_mem[ch][t_pk] + smp_mem[ch][t_pk+1]) >> 1;
        b = (smp_mem[ch][t_bs] + smp_mem[ch][t_bs+1]
           + smp_mem[ch][t_bs+2] + smp_mem[ch][t_bs+3]) >> 2;
        if (t_mode) return (p >= b) && ((p - b) >= t_thr);
        return p >= t_thr;
    endfunction

    task automatic step();
        @(negedge clk);
        cyc++;
        if (res_valid) begin
            if (ptr >= n_exp) begin
                chk(1'b0, "R9", "result while none owed", int'(res_chan), -1);
            end else begin
                chk(cyc == due[ptr], "R7", "result cycle", cyc, due[ptr]);
                chk(int'(res_chan) == ptr, "R7", "result channel", int'(res_chan), ptr);
                chk(res_hit == exp_hit[ptr], t_tag, "hit decision", int'(res_hit), int'(exp_hit[ptr]));
                ptr++;
            end
        end
        if (ptr < n_exp && cyc > due[ptr]) begin
            chk(1'b0, "R7", "missing result", cyc, due[ptr]);
            ptr++;
        end
        if (mask_valid) begin
            chk(hit_mask == exp_mask, "R8", "hit mask", int'(hit_mask), int'(exp_mask));
            chk(ptr == NCH && n_exp == NCH, "R8", "mask timing", ptr, NCH);
        end
    endtask

    task automatic idle(int n);
        smp_valid = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic start_trig(bit mode, int thr, int pk, int bs);
        t_mode = mode; t_thr = thr; t_pk = pk; t_bs = bs;
        exp_mask = '0;
        for (int c = 0; c < NCH; c++) begin
            exp_hit[c] = model_hit(c);
            exp_mask[c] = exp_hit[c];
            due[c] = 32'h7fffffff;
        end
        n_exp = NCH;
        ptr = 0;
        smp_valid = 1'b0;
        trig_start = 1'b1;
        cfg_mode = mode;
        cfg_thr = 18'(thr);
        cfg_peak_idx = 5'(pk);
        cfg_base_idx = 5'(bs);
        step();
        trig_start = 1'b0;
        // R6: scramble the configuration inputs after capture
        cfg_mode = ~mode;
        cfg_thr = 18'($urandom_range(0, 3000));
        cfg_peak_idx = 5'($urandom_range(0, NS - 2));
        cfg_base_idx = 5'($urandom_range(0, NS - 4));
        chk(hit_mask == '0, "R10", "mask cleared by trigger start", int'(hit_mask), 0);
    endtask

    task automatic send_chan(int ch, int gap_pct);
        for (int i = 0; i < NS; i++) begin
            while (gap_pct > 0 && $urandom_range(0, 99) < gap_pct) begin
                smp_valid = 1'b0;
                step();
            end
            smp_valid = 1'b1;
            smp_data = 18'(smp_mem[ch][i]);
            if (i == NS - 1) due[ch] = cyc + 2;
            step();
        end
        smp_valid = 1'b0;
    endtask

    task automatic run_trig(bit mode, int thr, int pk, int bs, int gap_pct, string tag);
        t_tag = tag;
        start_trig(mode, thr, pk, bs);
        for (int c = 0; c < NCH; c++) send_chan(c, gap_pct);
        idle(4);
        chk(ptr == NCH, tag, "all channels reported", ptr, NCH);
        // R9: samples after the last channel must produce nothing
        for (int i = 0; i < 40; i++) begin
            smp_valid = 1'b1;
            smp_data = 18'($urandom_range(0, 4000));
            step();
        end
        idle(4);
        chk(hit_mask == exp_mask, "R9", "mask held after extra samples", int'(hit_mask), int'(exp_mask));
    endtask

    task automatic fill_flat(int level, int pk);
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < NS; i++) smp_mem[c][i] = level;
        for (int c = 0; c < NCH; c++) begin
            smp_mem[c][pk] = level;
            smp_mem[c][pk+1] = level;
        end
    endtask

    task automatic fill_random(int pk);
        for (int c = 0; c < NCH; c++) begin
            int base, amp;
            base = $urandom_range(500, 3000);
            amp = $urandom_range(0, 400);
            for (int i = 0; i < NS; i++)
                smp_mem[c][i] = base + $urandom_range(0, 14) - 7;
            smp_mem[c][pk] = base + amp;
            smp_mem[c][pk+1] = base + amp + $urandom_range(0, 3) - 1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "R7", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        for (int i = 0; i < 3; i++) step();
        chk(!res_valid && !mask_valid && hit_mask == '0, "R1", "outputs during reset",
            int'({res_valid, mask_valid}) + int'(hit_mask), 0);
        rst_n = 1'b1;
        step();
        chk(!res_valid && !mask_valid && hit_mask == '0, "R1", "outputs after reset",
            int'({res_valid, mask_valid}) + int'(hit_mask), 0);

        // R9: samples before any trigger are ignored
        for (int i = 0; i < 70; i++) begin
            smp_valid = 1'b1;
            smp_data = 18'($urandom_range(0, 4000));
            step();
        end
        idle(3);
        chk(hit_mask == '0, "R9", "mask untouched before trigger", int'(hit_mask), 0);

        // R4: differential mode, threshold 0, peak under baseline
        fill_flat(100, 10);
        smp_mem[0][10] = 90;  smp_mem[0][11] = 90;   // below baseline: no hit
        smp_mem[1][10] = 100; smp_mem[1][11] = 101;  // equal levels: hit
        smp_mem[2][10] = 99;  smp_mem[2][11] = 99;   // one below: no hit
        run_trig(1'b1, 0, 10, 2, 0, "R4");

        // R2 and R3: rounding of both averages and the threshold edge
        fill_flat(100, 10);
        smp_mem[0][10] = 140; smp_mem[0][11] = 140;  // diff 40: hit
        smp_mem[1][10] = 139; smp_mem[1][11] = 140;  // floor 139: no hit
        smp_mem[2][10] = 140; smp_mem[2][11] = 141;  // floor 140: hit
        smp_mem[3][10] = 140; smp_mem[3][11] = 140; smp_mem[3][5] = 103; // base floor 100: hit
        for (int i = 2; i < 6; i++) smp_mem[4][i] = 101;
        smp_mem[4][10] = 140; smp_mem[4][11] = 140;  // diff 39: no hit
        run_trig(1'b1, 40, 10, 2, 0, "R2");

        // R5: absolute mode ignores the baseline
        fill_flat(3000, 12);
        smp_mem[0][12] = 499; smp_mem[0][13] = 500;  // 499: no hit
        smp_mem[1][12] = 500; smp_mem[1][13] = 500;  // 500: hit
        smp_mem[2][12] = 400; smp_mem[2][13] = 400;  // high baseline, low peak
        for (int i = 0; i < NS; i++) smp_mem[3][i] = 0;
        smp_mem[3][12] = 600; smp_mem[3][13] = 600;
        run_trig(1'b0, 500, 12, 4, 0, "R5");

        // R10: restart in the middle of a trigger
        fill_flat(100, 10);
        for (int c = 0; c < NCH; c++) begin smp_mem[c][10] = 200; smp_mem[c][11] = 200; end
        t_tag = "R10";
        start_trig(1'b1, 10, 10, 2);
        for (int c = 0; c < 3; c++) send_chan(c, 0);
        idle(4);
        chk(ptr == 3, "R10", "results before restart", ptr, 3);
        for (int i = 0; i < 12; i++) begin
            smp_valid = 1'b1;
            smp_data = 18'(100);
            step();
        end
        smp_valid = 1'b0;
        fill_random(14);
        run_trig(1'b1, 60, 14, 6, 0, "R10");

        // Constrained random triggers in both modes
        for (int t = 0; t < 12; t++) begin
            int pk, bs, thr, gap;
            bit mode;
            string tag;
            pk = $urandom_range(4, NS - 2);
            bs = $urandom_range(0, pk - 4);
            mode = (t % 3) != 2;
            thr = mode ? $urandom_range(0, 250) : $urandom_range(400, 3000);
            gap = (t >= 9) ? 30 : 0;
            tag = (t >= 9) ? "R11" : ((t >= 6) ? "R6" : (mode ? "R3" : "R5"));
            fill_random(pk);
            run_trig(mode, thr, pk, bs, gap, tag);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule